// File: doc/BRIEF.md
# Mask-Driven Bit Scatter/Gather Unit

The unit rearranges the bits of one word under control of a mask word. In scatter mode the lowest source bits are spread out, in order, onto the positions where the mask holds a one. In gather mode the source bits sitting under the mask's ones are collected, in order, into a packed field at the low end of the result. The word width is a parameter, 32 or 64.

A request is a single-cycle `start_i` pulse together with the source, the mask and the mode. The unit then walks the mask one set bit per cycle, from the least significant upward. In each step it finds the lowest remaining one by its trailing-zero index, and removes it by ANDing the remaining mask with itself minus one. When no ones remain, it raises `done_o` for one cycle. The result stays on `result_o` until the next accepted request.

Top module: `pdx_unit`

## Requirements
- R1: Scatter mode (`op_i` = 0): for each k, the k-th lowest set bit of the mask takes source bit k.
- R2: Gather mode (`op_i` = 1): result bit k takes the source bit found at the k-th lowest set mask position, so gathering the scatter of x under mask m gives x truncated to popcount(m) bits.
- R3: Every result bit that the mode's mapping does not write is zero: outside the mask in scatter mode, and at or above popcount(mask) in gather mode.
- R4: Exactly one mask bit is consumed per working cycle, always the lowest one still remaining.
- R5: `done_o` rises popcount(mask)+1 clock edges after the edge that samples `start_i`, and lasts one cycle.
- R6: `busy_o` is high in every cycle from the accepting edge until `done_o` rises, and is low while `done_o` is high.
- R7: A `start_i` pulse while `busy_o` is high is ignored: the running request's result is unchanged.
- R8: An all-zero mask yields a zero result, with `done_o` on the first edge after acceptance.
- R9: While the unit is idle, `result_o` holds the last result until a new request is accepted.
- R10: After reset, `busy_o`, `done_o` and `result_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request pulse, taken only when idle |
| op_i | input | 1 | Mode: 0 scatter, 1 gather |
| src_i | input | WIDTH | Source word |
| mask_i | input | WIDTH | Mask word |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | WIDTH | Result, held while idle |

## Verification
On every cycle, the assertions check the walk itself. Each working step removes one mask bit, and that bit lies below every bit that remains. Scatter never sets a bit still waiting in the mask. The completion pulse is single and never coincides with busy. Start pulses during a request leave the captured operands untouched, and the result holds while idle. The bit mappings themselves, the exact latency and the gather-of-scatter identity show up only in the bench. Its scenarios sweep single-bit, contiguous, alternating, full, empty and pseudo-random masks against loop-based reference models.

// File: rtl/pdx_pkg.sv
package pdx_pkg;
  typedef enum logic {
    PDX_SCATTER = 1'b0,
    PDX_GATHER  = 1'b1
  } pdx_op_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WALK = 1'b1
  } pdx_state_e;
endpackage

// File: rtl/pdx_lsb_pick.sv
// Isolates the lowest set bit of the remaining mask and reports its index.
module pdx_lsb_pick #(
  parameter int WIDTH = 32,
  localparam int IW = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] rem_i,
  output logic [WIDTH-1:0] onehot_o,
  output logic [IW-1:0]    idx_o,
  output logic             any_o
);
  // two's complement trick: x & -x keeps only the lowest one
  assign onehot_o = rem_i & (~rem_i + {{(WIDTH-1){1'b0}}, 1'b1});
  assign any_o    = |rem_i;

  // trailing-zero count as a priority encoder, lowest bit wins
  always_comb begin
    idx_o = '0;
    for (int i = WIDTH - 1; i >= 0; i--) begin
      if (rem_i[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/pdx_ctrl.sv
// Sequencer: accepts a request, counts steps, signals completion.
module pdx_ctrl #(
  parameter int WIDTH = 32,
  localparam int CW = $clog2(WIDTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          rem_zero_i,
  output logic          accept_o,
  output logic          step_o,
  output logic          busy_o,
  output logic          done_o,
  output logic [CW-1:0] cnt_o
);
  import pdx_pkg::*;

  pdx_state_e    state_q, state_d;
  logic          done_q, done_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          finish;
  logic          cnt_en;

  assign accept_o = start_i && (state_q == ST_IDLE);
  assign step_o   = (state_q == ST_WALK) && !rem_zero_i;
  assign finish   = (state_q == ST_WALK) && rem_zero_i;
  assign cnt_en   = accept_o || step_o;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (accept_o) state_d = ST_WALK;
      ST_WALK: if (finish)   state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
    done_d = finish;
    cnt_d  = accept_o ? '0 : cnt_q + {{(CW-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign busy_o = (state_q == ST_WALK);
  assign done_o = done_q;
  assign cnt_o  = cnt_q;

  // R6: completion and busy never overlap
  a_r6_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);
  // R5: completion is a single-cycle pulse
  a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R8: an exhausted mask ends the request on the next edge
  a_r8_empty_finishes: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && rem_zero_i) |=> (done_o && !busy_o));
endmodule

// File: rtl/pdx_unit.sv
// Top: operand capture, per-step bit routing, result accumulation.
module pdx_unit #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             op_i,
  input  logic [WIDTH-1:0] src_i,
  input  logic [WIDTH-1:0] mask_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [WIDTH-1:0] result_o
);
  import pdx_pkg::*;

  localparam int CW = $clog2(WIDTH);
  localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

  logic [WIDTH-1:0] src_q, src_d;
  logic [WIDTH-1:0] rem_q, rem_d;
  logic [WIDTH-1:0] res_q, res_d;
  pdx_op_e          op_q, op_d;

  logic             accept, step;
  logic [CW-1:0]    cnt;
  logic [WIDTH-1:0] pick_onehot;
  logic [CW-1:0]    pick_idx;
  logic             pick_any;
  logic             route_bit;
  logic [WIDTH-1:0] route_dst;
  logic             load_en;

  pdx_lsb_pick #(.WIDTH(WIDTH)) u_pick (
    .rem_i    (rem_q),
    .onehot_o (pick_onehot),
    .idx_o    (pick_idx),
    .any_o    (pick_any)
  );

  pdx_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .rem_zero_i (!pick_any),
    .accept_o   (accept),
    .step_o     (step),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .cnt_o      (cnt)
  );

  // Scatter: source index is the step count, destination the picked bit.
  // Gather:  source index is the picked bit, destination the step count.
  always_comb begin
    if (op_q == PDX_SCATTER) begin
      route_bit = src_q[cnt];
      route_dst = pick_onehot;
    end else begin
      route_bit = src_q[pick_idx];
      route_dst = ONE << cnt;
    end
  end

  assign load_en = accept || step;

  always_comb begin
    src_d = src_q;
    op_d  = op_q;
    rem_d = rem_q;
    res_d = res_q;
    if (accept) begin
      src_d = src_i;
      op_d  = pdx_op_e'(op_i);
      rem_d = mask_i;
      res_d = '0;
    end else if (step) begin
      rem_d = rem_q & (rem_q - ONE);
      res_d = res_q | (route_bit ? route_dst : '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0;
      rem_q <= '0;
      res_q <= '0;
      op_q  <= PDX_SCATTER;
    end else if (load_en) begin
      src_q <= src_d;
      rem_q <= rem_d;
      res_q <= res_d;
      op_q  <= op_d;
    end
  end

  assign result_o = res_q;

  // R4: each working step removes exactly one mask bit
  a_r4_one_per_step: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && (rem_q != '0)) |=> ($countones(rem_q) == $countones($past(rem_q)) - 1));
  // R4: the removed bit lies below every bit that remains
  a_r4_lowest_first: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && (rem_q != '0)) |=> (((($past(rem_q) ^ rem_q) - ONE) & rem_q) == '0));
  // R4: the encoder index and the isolated bit agree
  a_r4_pick_agrees: assert property (@(posedge clk) disable iff (!rst_n)
    pick_any |-> (pick_onehot == (ONE << pick_idx)));
  // R3: scatter never touches a position still pending in the mask
  a_r3_pending_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && (op_q == PDX_SCATTER)) |-> ((res_q & rem_q) == '0));
  // R7: a start during a request leaves the captured operands alone
  a_r7_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> ($stable(src_q) && $stable(op_q)));
  // R9: idle without a request keeps the result
  a_r9_result_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> $stable(result_o));
endmodule

// File: tb/pdx_unit_tb.sv
`timescale 1ns/1ps
module pdx_unit_tb_top;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start_i = 1'b0;
  logic         op_i = 1'b0;
  logic [W-1:0] src_i = '0;
  logic [W-1:0] mask_i = '0;
  logic         busy_o, done_o;
  logic [W-1:0] result_o;

  int checks = 0;
  int fails = 0;
  logic [31:0] seed = 32'h1badf00d;

  always #2 clk = ~clk;

  pdx_unit #(.WIDTH(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
    .src_i(src_i), .mask_i(mask_i),
    .busy_o(busy_o), .done_o(done_o), .result_o(result_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] ref_scatter(input logic [W-1:0] s, input logic [W-1:0] m);
    logic [W-1:0] r = '0;
    int k = 0;
    for (int i = 0; i < W; i++) if (m[i]) begin r[i] = s[k]; k++; end
    return r;
  endfunction

  function automatic logic [W-1:0] ref_gather(input logic [W-1:0] s, input logic [W-1:0] m);
    logic [W-1:0] r = '0;
    int k = 0;
    for (int i = 0; i < W; i++) if (m[i]) begin r[k] = s[i]; k++; end
    return r;
  endfunction

  function automatic int pop(input logic [W-1:0] m);
    int n = 0;
    for (int i = 0; i < W; i++) n += int'(m[i]);
    return n;
  endfunction

  function automatic logic [W-1:0] low_ones(input int n);
    logic [W-1:0] r = '0;
    for (int i = 0; i < n; i++) r[i] = 1'b1;
    return r;
  endfunction

  function automatic logic [31:0] xs(input logic [31:0] v);
    logic [31:0] x = v;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  // Runs one request; optionally pulses start with other operands mid-run.
  task automatic run_op(input logic op, input logic [W-1:0] s, input logic [W-1:0] m,
                        input bit inject, output logic [W-1:0] res, output int lat);
    @(negedge clk);
    start_i = 1'b1; op_i = op; src_i = s; mask_i = m;
    @(negedge clk);
    start_i = 1'b0;
    lat = 0;
    while (!done_o && lat < 200) begin
      chk(busy_o == 1'b1, "R6 busy during request", 64'(busy_o), 64'd1);
      if (inject && lat == 0) begin
        start_i = 1'b1; op_i = ~op; src_i = ~s; mask_i = ~m;
      end
      @(negedge clk);
      start_i = 1'b0;
      lat++;
    end
    chk(busy_o == 1'b0, "R6 busy low at done", 64'(busy_o), 64'd0);
    res = result_o;
    @(negedge clk);
    chk(done_o == 1'b0, "R5 done single cycle", 64'(done_o), 64'd0);
    chk(result_o == res, "R9 result held while idle", 64'(result_o), 64'(res));
  endtask

  task automatic check_pair(input logic [W-1:0] s, input logic [W-1:0] m);
    logic [W-1:0] r1, r2;
    int lat;
    int p = pop(m);
    run_op(1'b0, s, m, 1'b0, r1, lat);
    chk(r1 == ref_scatter(s, m), "R1 scatter mapping", 64'(r1), 64'(ref_scatter(s, m)));
    chk((r1 & ~m) == '0, "R3 scatter outside mask zero", 64'(r1 & ~m), 64'd0);
    chk(lat == p + 1, "R5 scatter latency", 64'(lat), 64'(p + 1));
    run_op(1'b1, s, m, 1'b0, r2, lat);
    chk(r2 == ref_gather(s, m), "R2 gather mapping", 64'(r2), 64'(ref_gather(s, m)));
    chk((r2 & ~low_ones(p)) == '0, "R3 gather upper zero", 64'(r2 & ~low_ones(p)), 64'd0);
    chk(lat == p + 1, "R5 gather latency", 64'(lat), 64'(p + 1));
    // R2 round trip: gather(scatter(s,m),m) == s truncated to popcount
    run_op(1'b1, r1, m, 1'b0, r2, lat);
    chk(r2 == (s & low_ones(p)), "R2 round trip", 64'(r2), 64'(s & low_ones(p)));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [W-1:0] r;
    int lat;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(busy_o == 1'b0, "R10 busy after reset", 64'(busy_o), 64'd0);
    chk(done_o == 1'b0, "R10 done after reset", 64'(done_o), 64'd0);
    chk(result_o == '0, "R10 result after reset", 64'(result_o), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R8: zero mask after a nonzero result
    run_op(1'b0, 32'hffffffff, 32'h000000f0, 1'b0, r, lat);
    run_op(1'b0, 32'hffffffff, 32'h0, 1'b0, r, lat);
    chk(r == '0, "R8 zero mask scatter result", 64'(r), 64'd0);
    chk(lat == 1, "R8 zero mask latency", 64'(lat), 64'd1);
    run_op(1'b1, 32'hffffffff, 32'h0, 1'b0, r, lat);
    chk(r == '0, "R8 zero mask gather result", 64'(r), 64'd0);

    // R7: start pulse during a run is ignored
    run_op(1'b0, 32'h0000a5c3, 32'hf0f00ff0, 1'b1, r, lat);
    chk(r == ref_scatter(32'h0000a5c3, 32'hf0f00ff0), "R7 scatter ignores busy start",
        64'(r), 64'(ref_scatter(32'h0000a5c3, 32'hf0f00ff0)));
    chk(lat == 17, "R7 latency unchanged", 64'(lat), 64'd17);
    run_op(1'b1, 32'h12345678, 32'h00ff0001, 1'b1, r, lat);
    chk(r == ref_gather(32'h12345678, 32'h00ff0001), "R7 gather ignores busy start",
        64'(r), 64'(ref_gather(32'h12345678, 32'h00ff0001)));
    // R9: idle cycles leave result unchanged
    repeat (5) @(negedge clk);
    chk(result_o == r, "R9 long idle hold", 64'(result_o), 64'(r));

    // Sweeps: edges, single bits, contiguous low fields, alternating, random
    check_pair(32'hdeadbeef, 32'hffffffff);
    check_pair(32'h5555aaaa, 32'h55555555);
    check_pair(32'h5555aaaa, 32'haaaaaaaa);
    check_pair(32'h80000001, 32'h80000001);
    for (int b = 0; b < W; b++) begin
      seed = xs(seed);
      check_pair(seed, 32'h1 << b);
    end
    for (int n = 1; n <= W; n++) begin
      seed = xs(seed);
      check_pair(seed, low_ones(n));
    end
    for (int t = 0; t < 120; t++) begin
      logic [W-1:0] s, m;
      seed = xs(seed); s = seed;
      seed = xs(seed); m = seed;
      if (t % 3 == 1) m = m & xs(m);
      check_pair(s, m);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule